// File: doc/BRIEF.md
# Framebuffer Scanout Display Controller

This block turns a true-colour image held in memory into a stream of RGB pixels with horizontal and vertical sync. It runs one fixed raster, 640 by 480 visible pixels inside an 800 by 525 clock frame by default. For each visible pixel it issues one word read to a memory port with a fixed return latency. It splits each returned 32-bit word into 8-bit red, green and blue, then drives those onto the display pins together with a data-enable flag.

Software sees two registers. Index 0 holds the frame-buffer base address, and only its upper bits are kept. Index 1 holds an enable bit and a 180-degree rotate bit. Rotation is done by walking the image backwards in memory, so software never has to copy it. A new base or rotate setting is picked up once per frame, on the first clock of vertical sync. A frame therefore always comes from a single setting. Enable acts at once.

Top module: `fbsc_top`

## Requirements
- R1: While reset is held and after it, both registers read 0, `mem_req` is 0, `disp_de` is 0, the colour outputs are 0 and both syncs are high.
- R2: A write to register index 0 keeps bits [ADDR_W-1:ADDR_W-KEEP_BITS] and clears all lower bits (default: top 11 of 32, a 2 MiB boundary). A read of index 0 returns the stored value.
- R3: At register index 1, bit 0 is enable and bit 1 is rotate. A read of index 1 returns them in the same positions, with all other bits 0.
- R4: The line counter spans H_ACT+H_FP+H_SW+H_BP clocks. `hsync` is low for H_SW clocks, starting H_ACT+H_FP clocks into the line. `vsync` is low for V_SW lines, starting V_ACT+V_FP lines into the frame, and both syncs are active low.
- R5: `mem_req` is 1 in exactly those clocks where the raster position is in the visible area and enable is 1.
- R6: With rotate off, pixel (x, y) reads byte address base + 4*(y*PITCH + x), so each row occupies PITCH words, of which H_ACT are read.
- R7: With rotate on, pixel (x, y) reads byte address base + 4*((V_ACT-1-y)*PITCH + (H_ACT-1-x)).
- R8: A returned word maps bits [23:16] to red, [15:8] to green and [7:0] to blue. Bits [31:24] have no effect.
- R9: The display outputs (syncs, `disp_de`, colour) lag the request-side raster by LAT+1 clocks. `disp_de` is 1 only for pixels that were requested, and the colour is 0 whenever `disp_de` is 0.
- R10: Base and rotate values written mid-frame are used starting from the clock after the first clock of the vsync line (line V_ACT+V_FP, pixel 0). Until then, the values latched at the previous such point stay in use.
- R11: Writing 0 to register index 1 blanks the display: no requests are issued, and the colour outputs stay 0 until enable is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 1 | Register index: 0 base, 1 control |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Read data of the register selected by reg_idx |
| mem_req | output | 1 | One-clock word read request |
| mem_addr | output | ADDR_W | Byte address of the requested word |
| mem_rdata | input | 32 | Word returned LAT clocks after its request |
| disp_hsync_n | output | 1 | Horizontal sync, active low |
| disp_vsync_n | output | 1 | Vertical sync, active low |
| disp_de | output | 1 | Pixel valid |
| disp_r | output | 8 | Red level |
| disp_g | output | 8 | Green level |
| disp_b | output | 8 | Blue level |

## Verification
The bench runs a reduced raster and compares every clock against a model built from the requirements. Directed phases cover four cases: a forward scan, a rotate write landing in the middle of a frame (which shows whether the latch waits for vsync), a blanked frame, and a read-back of an all-ones base. These are followed by random register writes at random clocks. Each memory word comes from an address hash with a non-zero top byte, so an ignored-bit leak, a swapped colour lane or an address one word off each shows up as a wrong colour.

// File: rtl/fbsc_pkg.sv
// Shared types for the scanout controller.
// Assumes pixel words are 32 bits with the colour in the low 24 bits.
package fbsc_pkg;

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } rgb_t;

    // Splits a memory word into its three colour lanes; the top byte is dropped.
    function automatic rgb_t word_to_rgb(input logic [31:0] w);
        rgb_t c;
        c.r = w[23:16];
        c.g = w[15:8];
        c.b = w[7:0];
        return c;
    endfunction

endpackage

// File: rtl/fbsc_regs.sv
// Register file: base address (index 0) and control (index 1).
// Assumes single-cycle writes; the read data is combinational on reg_idx.
module fbsc_regs #(
    parameter int ADDR_W    = 32,
    parameter int KEEP_BITS = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_idx,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    output logic [ADDR_W-1:0] base_o,
    output logic              en_o,
    output logic              rot_o
);
    localparam int DROP = ADDR_W - KEEP_BITS;

    logic [ADDR_W-1:0] base_q;
    logic              en_q;
    logic              rot_q;
    logic              unused_wbits;

    assign unused_wbits = ^reg_wdata[DROP-1:2];

    // Register write: base keeps its upper bits only, control keeps two bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            en_q   <= 1'b0;
            rot_q  <= 1'b0;
        end else if (reg_we) begin
            if (!reg_idx) begin
                base_q <= {reg_wdata[ADDR_W-1:DROP], {DROP{1'b0}}};
            end else begin
                en_q  <= reg_wdata[0];
                rot_q <= reg_wdata[1];
            end
        end
    end

    // Read mux on the selected index.
    always_comb begin
        if (reg_idx) reg_rdata = {{(ADDR_W-2){1'b0}}, rot_q, en_q};
        else         reg_rdata = base_q;
    end

    assign base_o = base_q;
    assign en_o   = en_q;
    assign rot_o  = rot_q;

    AST_BASE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        base_q[DROP-1:0] == '0); // R2

endmodule

// File: rtl/fbsc_timing.sv
// Raster counters and fetch-side sync generation.
// Assumes the blanking intervals are non-zero. The outputs describe the
// pixel being fetched, not the pixel on the pins.
module fbsc_timing #(
    parameter int H_ACT = 640,
    parameter int H_FP  = 16,
    parameter int H_SW  = 96,
    parameter int H_BP  = 48,
    parameter int V_ACT = 480,
    parameter int V_FP  = 10,
    parameter int V_SW  = 2,
    parameter int V_BP  = 33,
    localparam int H_TOT = H_ACT + H_FP + H_SW + H_BP,
    localparam int V_TOT = V_ACT + V_FP + V_SW + V_BP,
    localparam int HCW   = $clog2(H_TOT),
    localparam int VCW   = $clog2(V_TOT)
) (
    input  logic           clk,
    input  logic           rst_n,
    output logic [HCW-1:0] hcnt,
    output logic [VCW-1:0] vcnt,
    output logic           active,
    output logic           hsync_n,
    output logic           vsync_n,
    output logic           frame_tick
);
    localparam int HS_BEG = H_ACT + H_FP;
    localparam int HS_END = HS_BEG + H_SW;
    localparam int VS_BEG = V_ACT + V_FP;
    localparam int VS_END = VS_BEG + V_SW;

    // Pixel and line counters, wrapping at the frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt <= '0;
            vcnt <= '0;
        end else if (hcnt == HCW'(H_TOT-1)) begin
            hcnt <= '0;
            vcnt <= (vcnt == VCW'(V_TOT-1)) ? '0 : vcnt + 1'b1;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

    // Area decode and sync pulses from the counters.
    always_comb begin
        active     = (hcnt < HCW'(H_ACT)) && (vcnt < VCW'(V_ACT));
        hsync_n    = !((hcnt >= HCW'(HS_BEG)) && (hcnt < HCW'(HS_END)));
        vsync_n    = !((vcnt >= VCW'(VS_BEG)) && (vcnt < VCW'(VS_END)));
        frame_tick = (hcnt == '0) && (vcnt == VCW'(VS_BEG));
    end

    AST_HCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        hcnt < HCW'(H_TOT)); // R4
    AST_VSYNC_AT_LINE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync_n != $past(vsync_n)) |-> (hcnt == '0)); // R4

endmodule

// File: rtl/fbsc_fetch.sv
// Per-frame shadow of base and rotate, and word address generation.
// Assumes PITCH >= H_ACT. Issues one request per visible pixel while enabled.
module fbsc_fetch #(
    parameter int ADDR_W = 32,
    parameter int H_ACT  = 640,
    parameter int V_ACT  = 480,
    parameter int PITCH  = 1024,
    parameter int HCW    = 10,
    parameter int VCW    = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HCW-1:0]    hcnt,
    input  logic [VCW-1:0]    vcnt,
    input  logic              active,
    input  logic              frame_tick,
    input  logic              en,
    input  logic              rot,
    input  logic [ADDR_W-1:0] base,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr
);
    logic [ADDR_W-1:0] sh_base;
    logic              sh_rot;
    logic [HCW-1:0]    xs;
    logic [VCW-1:0]    ys;
    logic [ADDR_W-1:0] off;

    // Latch base and rotate once per frame, at the first vsync clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_base <= '0;
            sh_rot  <= 1'b0;
        end else if (frame_tick) begin
            sh_base <= base;
            sh_rot  <= rot;
        end
    end

    // Mirror the coordinates when rotated and form the byte address.
    always_comb begin
        xs       = sh_rot ? HCW'(H_ACT-1) - hcnt : hcnt;
        ys       = sh_rot ? VCW'(V_ACT-1) - vcnt : vcnt;
        off      = ADDR_W'(ys) * ADDR_W'(PITCH) + ADDR_W'(xs);
        mem_addr = sh_base + (off << 2);
        mem_req  = en && active;
    end

    AST_SHADOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> ($stable(sh_base) && $stable(sh_rot))); // R10

endmodule

// File: rtl/fbsc_pixout.sv
// Aligns syncs and the request flag with returned memory data and registers
// the pins. Assumes the memory answers exactly LAT clocks after a request.
module fbsc_pixout #(
    parameter int LAT = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_i,
    input  logic        hsync_n_i,
    input  logic        vsync_n_i,
    input  logic [31:0] mem_rdata,
    output logic        disp_hsync_n,
    output logic        disp_vsync_n,
    output logic        disp_de,
    output logic [7:0]  disp_r,
    output logic [7:0]  disp_g,
    output logic [7:0]  disp_b
);
    import fbsc_pkg::*;

    logic [LAT-1:0] req_p;
    logic [LAT-1:0] hs_p;
    logic [LAT-1:0] vs_p;
    rgb_t           px;
    logic           unused_top;

    assign px         = word_to_rgb(mem_rdata);
    assign unused_top = ^mem_rdata[31:24];

    // Delay line covering the memory latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_p <= '0;
            hs_p  <= '1;
            vs_p  <= '1;
        end else begin
            req_p[0] <= req_i;
            hs_p[0]  <= hsync_n_i;
            vs_p[0]  <= vsync_n_i;
            for (int i = 1; i < LAT; i++) begin
                req_p[i] <= req_p[i-1];
                hs_p[i]  <= hs_p[i-1];
                vs_p[i]  <= vs_p[i-1];
            end
        end
    end

    // Output register: colour only for requested pixels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_hsync_n <= 1'b1;
            disp_vsync_n <= 1'b1;
            disp_de      <= 1'b0;
            disp_r       <= '0;
            disp_g       <= '0;
            disp_b       <= '0;
        end else begin
            disp_hsync_n <= hs_p[LAT-1];
            disp_vsync_n <= vs_p[LAT-1];
            disp_de      <= req_p[LAT-1];
            disp_r       <= req_p[LAT-1] ? px.r : 8'd0;
            disp_g       <= req_p[LAT-1] ? px.g : 8'd0;
            disp_b       <= req_p[LAT-1] ? px.b : 8'd0;
        end
    end

    AST_RGB_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_de |-> ({disp_r, disp_g, disp_b} == 24'd0)); // R9

endmodule

// File: rtl/fbsc_top.sv
// Scanout controller top: registers, raster timing, fetch and pixel output.
// Assumes a read port with fixed latency LAT and no back-pressure.
module fbsc_top #(
    parameter int ADDR_W    = 32,
    parameter int KEEP_BITS = 11,
    parameter int PITCH     = 1024,
    parameter int LAT       = 2,
    parameter int H_ACT     = 640,
    parameter int H_FP      = 16,
    parameter int H_SW      = 96,
    parameter int H_BP      = 48,
    parameter int V_ACT     = 480,
    parameter int V_FP      = 10,
    parameter int V_SW      = 2,
    parameter int V_BP      = 33
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_idx,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [31:0]       mem_rdata,
    output logic              disp_hsync_n,
    output logic              disp_vsync_n,
    output logic              disp_de,
    output logic [7:0]        disp_r,
    output logic [7:0]        disp_g,
    output logic [7:0]        disp_b
);
    localparam int H_TOT = H_ACT + H_FP + H_SW + H_BP;
    localparam int V_TOT = V_ACT + V_FP + V_SW + V_BP;
    localparam int HCW   = $clog2(H_TOT);
    localparam int VCW   = $clog2(V_TOT);

    logic [ADDR_W-1:0] base;
    logic              en;
    logic              rot;
    logic [HCW-1:0]    hcnt;
    logic [VCW-1:0]    vcnt;
    logic              active;
    logic              hs_n;
    logic              vs_n;
    logic              frame_tick;

    fbsc_regs #(.ADDR_W(ADDR_W), .KEEP_BITS(KEEP_BITS)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .base_o(base), .en_o(en), .rot_o(rot)
    );

    fbsc_timing #(
        .H_ACT(H_ACT), .H_FP(H_FP), .H_SW(H_SW), .H_BP(H_BP),
        .V_ACT(V_ACT), .V_FP(V_FP), .V_SW(V_SW), .V_BP(V_BP)
    ) u_timing (
        .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .vcnt(vcnt), .active(active),
        .hsync_n(hs_n), .vsync_n(vs_n), .frame_tick(frame_tick)
    );

    fbsc_fetch #(
        .ADDR_W(ADDR_W), .H_ACT(H_ACT), .V_ACT(V_ACT), .PITCH(PITCH),
        .HCW(HCW), .VCW(VCW)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .vcnt(vcnt), .active(active),
        .frame_tick(frame_tick), .en(en), .rot(rot), .base(base),
        .mem_req(mem_req), .mem_addr(mem_addr)
    );

    fbsc_pixout #(.LAT(LAT)) u_pixout (
        .clk(clk), .rst_n(rst_n), .req_i(mem_req), .hsync_n_i(hs_n),
        .vsync_n_i(vs_n), .mem_rdata(mem_rdata),
        .disp_hsync_n(disp_hsync_n), .disp_vsync_n(disp_vsync_n),
        .disp_de(disp_de), .disp_r(disp_r), .disp_g(disp_g), .disp_b(disp_b)
    );

endmodule

// File: tb/fbsc_top_tb.sv
// Self-checking bench: a reduced raster, a fixed-latency hashed memory and a
// per-clock model built from the requirements.
module fbsc_top_tb;
    localparam int AW = 32, KEEP = 11, PITCH = 16, LAT = 3;
    localparam int HA = 8, HF = 2, HS = 3, HB = 2;
    localparam int VA = 4, VF = 1, VS = 1, VB = 2;
    localparam int HT = HA + HF + HS + HB;
    localparam int VT = VA + VF + VS + VB;
    localparam int D  = LAT + 1;
    localparam logic [AW-1:0] KEEP_MASK = ~((32'd1 << (AW - KEEP)) - 32'd1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_we = 1'b0, reg_idx = 1'b0;
    logic [AW-1:0] reg_wdata = '0, reg_rdata, mem_addr;
    logic mem_req, hs_n, vs_n, de;
    logic [31:0] mem_rdata;
    logic [7:0] r, g, b;

    int checks = 0, fails = 0, k = 0, req_cnt = 0;
    bit run_model = 0, done = 0;
    logic [AW-1:0] rm_base = '0, sh_base = '0;
    logic rm_en = 0, rm_rot = 0, sh_rot = 0;
    logic q_de [D];
    logic q_hs [D];
    logic q_vs [D];
    logic [23:0] q_rgb [D];
    logic [31:0] mpipe [LAT];

    always #2.5 clk = ~clk;

    fbsc_top #(.ADDR_W(AW), .KEEP_BITS(KEEP), .PITCH(PITCH), .LAT(LAT),
        .H_ACT(HA), .H_FP(HF), .H_SW(HS), .H_BP(HB),
        .V_ACT(VA), .V_FP(VF), .V_SW(VS), .V_BP(VB)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .disp_hsync_n(hs_n),
        .disp_vsync_n(vs_n), .disp_de(de), .disp_r(r), .disp_g(g), .disp_b(b)
    );

    function automatic logic [31:0] memf(input logic [31:0] a);
        return a * 32'h9E3779B1 + 32'h5A5A1234;
    endfunction

    function automatic logic [31:0] exp_addr(input logic [31:0] bs, input logic rt,
                                             input int x, input int y);
        int xs, ys;
        xs = rt ? HA - 1 - x : x;
        ys = rt ? VA - 1 - y : y;
        return bs + 32'((ys * PITCH + xs) * 4);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Fixed-latency memory: data appears LAT clocks after the request.
    always @(posedge clk) begin
        mpipe[0] <= memf(mem_addr);
        for (int i = 1; i < LAT; i++) mpipe[i] <= mpipe[i-1];
        if (rst_n) k <= k + 1;
    end
    assign mem_rdata = mpipe[LAT-1];

    // Per-clock reference model, evaluated away from the active edge.
    always @(negedge clk) begin
        if (rst_n && run_model) begin
            int p, h, v;
            logic act, xhs, xvs, xreq;
            logic [31:0] ea;
            p = k % (HT * VT);
            h = p % HT;
            v = p / HT;
            act  = (h < HA) && (v < VA);
            xhs  = !((h >= HA + HF) && (h < HA + HF + HS));
            xvs  = !((v >= VA + VF) && (v < VA + VF + VS));
            xreq = act && rm_en;
            ea   = exp_addr(sh_base, sh_rot, h, v);
            if (mem_req) req_cnt++;
            if (rm_en) chk(mem_req == xreq, "R5 request", 32'(mem_req), 32'(xreq));
            else       chk(mem_req == 1'b0, "R11 blank request", 32'(mem_req), 0);
            if (xreq)
                chk(mem_addr == ea, (sh_base != rm_base || sh_rot != rm_rot) ? "R10 address" :
                    (sh_rot ? "R7 address" : "R6 address"), mem_addr, ea);
            chk(hs_n == q_hs[D-1], "R4 hsync", 32'(hs_n), 32'(q_hs[D-1]));
            chk(vs_n == q_vs[D-1], "R4 vsync", 32'(vs_n), 32'(q_vs[D-1]));
            chk(de == q_de[D-1], "R9 de", 32'(de), 32'(q_de[D-1]));
            chk({r, g, b} == q_rgb[D-1], "R8 colour", 32'({r, g, b}), 32'(q_rgb[D-1]));
            for (int i = D - 1; i > 0; i--) begin
                q_de[i] = q_de[i-1]; q_hs[i] = q_hs[i-1];
                q_vs[i] = q_vs[i-1]; q_rgb[i] = q_rgb[i-1];
            end
            q_de[0] = xreq; q_hs[0] = xhs; q_vs[0] = xvs;
            q_rgb[0] = xreq ? memf(ea)[23:0] : 24'd0;
            if (h == 0 && v == VA + VF) begin
                sh_base = rm_base;
                sh_rot  = rm_rot;
            end
        end
    end

    task automatic wr(input logic idx, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_idx = idx; reg_wdata = d;
        @(posedge clk);
        if (!idx) rm_base = d & KEEP_MASK;
        else begin rm_en = d[0]; rm_rot = d[1]; end
        #1 reg_we = 1'b0;
    endtask

    task automatic rd(input logic idx, output logic [31:0] d);
        @(negedge clk);
        reg_idx = idx;
        #0.5 d = reg_rdata;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            summary();
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd4242));
        for (int i = 0; i < D; i++) begin
            q_de[i] = 0; q_hs[i] = 1; q_vs[i] = 1; q_rgb[i] = 0;
        end
        repeat (3) @(posedge clk);
        // R1: idle pins and cleared registers during reset
        @(negedge clk);
        chk({mem_req, de, hs_n, vs_n} == 4'b0011, "R1 pins", 32'({mem_req, de, hs_n, vs_n}), 32'h3);
        chk({r, g, b} == 0, "R1 colour", 32'({r, g, b}), 0);
        rd(0, d); chk(d == 0, "R1 base reset", d, 0);
        rd(1, d); chk(d == 0, "R1 ctrl reset", d, 0);
        @(negedge clk);
        rst_n = 1'b1;
        run_model = 1;
        // R2: low bits dropped, read-back matches the stored value
        wr(0, 32'hFFFF_FFFF);
        rd(0, d); chk(d == 32'hFFE0_0000, "R2 base readback", d, 32'hFFE0_0000);
        wr(0, 32'h0123_4567);
        rd(0, d); chk(d == (32'h0123_4567 & KEEP_MASK), "R2 base mask", d, 32'h0123_4567 & KEEP_MASK);
        // R3: control bits in positions 0 and 1, rest read zero
        wr(1, 32'hFFFF_FFFE);
        rd(1, d); chk(d == 32'h2, "R3 ctrl readback", d, 2);
        wr(1, 32'h0000_0001);
        rd(1, d); chk(d == 32'h1, "R3 ctrl enable", d, 1);
        // R6/R8: forward scan for two frames
        wr(0, 32'h0020_0000);
        repeat (2 * HT * VT) @(posedge clk);
        // R10/R7: rotate written in mid-frame, picked up at vsync
        repeat (HT + 3) @(posedge clk);
        wr(1, 32'h3);
        wr(0, 32'h0040_0000);
        repeat (2 * HT * VT) @(posedge clk);
        // R11: blank for a full frame and count requests
        wr(1, 32'h0);
        req_cnt = 0;
        repeat (HT * VT + 5) @(posedge clk);
        chk(req_cnt == 0, "R11 no requests", req_cnt, 0);
        // Random register traffic at random clocks
        for (int n = 0; n < 24; n++) begin
            repeat ($urandom % 150) @(posedge clk);
            if ($urandom % 2) wr(0, $urandom);
            else              wr(1, $urandom % 4);
        end
        wr(1, 32'h1);
        repeat (2 * HT * VT) @(posedge clk);
        done = 1;
        summary();
    end

endmodule